// File: doc/BRIEF.md
# Standby Mode Control Unit

This unit governs the low-power states of a small 8-bit processor core. It keeps a standby control word that software reads over the ordinary data bus. That word changes only through a separate protected-write strobe, which the core raises for one cycle when it executes its dedicated standby-store operation. Ordinary bus stores aimed at the word have no effect.

Setting the halt bit gates the CPU clock enable. The oscillator and the peripheral clock keep running, so peripherals and background transfer engines continue to work. Any interrupt request that is raised and not masked releases the halt on the next clock edge, and the halt bit then clears itself. A halt request made while such a request is already present is refused.

While halted, the unit takes over the external bus pins and drives each pin group to a fixed state:

- The multiplexed address/data byte floats.
- The middle address byte holds its last value.
- The top address nibble goes low.
- The read and write strobes go high.
- The address strobe goes low.

Stop mode is kept only as a register bit, which drives an oscillator-stop output and clears on the same release condition.

Top module: `stby_ctrl_top`

## Requirements
- R1: After reset the control word reads 0x00, cpuClkEn is 1, oscStop is 0 and busOverride is 0.
- R2: While busRdEn is 1, rdData shows the control word: bit 0 is the halt bit, bit 1 is the stop bit, and bits 7..2 read 0. While busRdEn is 0, rdData is 0x00.
- R3: A generic bus write (busWrEn with any busWdata) never changes the control word.
- R4: A protected write in the running state with data bit 0 = 1, bit 1 = 0 and no pending request sets the halt bit on that clock edge. From the next cycle on, cpuClkEn is 0 and busOverride is 1.
- R5: A protected halt write made while some irqReq bit is 1 with its irqMask bit 0 leaves the halt bit clear and cpuClkEn at 1.
- R6: While halted, a pending unmasked request clears the halt bit on the next clock edge. A request whose irqMask bit is 1 does not release the halt.
- R7: A protected write with data bit 1 = 1 sets the stop bit and leaves the halt bit 0, even when bit 0 is also 1. While stopped, oscStop is 1 and cpuClkEn is 0. A pending unmasked request clears the stop bit on the next edge.
- R8: While halted: pinAdOe is 0, pinAd is 0, pinAddrMid holds the cpuAddrMid value sampled on the entry edge, pinAddrHi is 0, pinRdN and pinWrN are 1, and pinAstb is 0.
- R9: While not halted, every bus pin output equals its cpu-side input.
- R10: Protected writes made while halted or stopped are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRdEn | input | 1 | Bus read of the control word |
| busWrEn | input | 1 | Generic bus write (ignored) |
| busWdata | input | 8 | Generic bus write data (ignored) |
| protWrEn | input | 1 | Protected-write strobe |
| protWdata | input | 8 | Protected-write data |
| rdData | output | 8 | Read data |
| irqReq | input | NUM_IRQ | Interrupt requests |
| irqMask | input | NUM_IRQ | Interrupt masks, 1 = masked |
| cpuAd | input | 8 | Core address/data output value |
| cpuAdOe | input | 1 | Core address/data output enable |
| cpuAddrMid | input | 8 | Core address bits 15..8 |
| cpuAddrHi | input | 4 | Core address bits 19..16 |
| cpuRdN | input | 1 | Core read strobe, active low |
| cpuWrN | input | 1 | Core write strobe, active low |
| cpuAstb | input | 1 | Core address strobe |
| pinAd | output | 8 | Address/data pin value |
| pinAdOe | output | 1 | Address/data pin enable |
| pinAddrMid | output | 8 | Address pins 15..8 |
| pinAddrHi | output | 4 | Address pins 19..16 |
| pinRdN | output | 1 | Read strobe pin |
| pinWrN | output | 1 | Write strobe pin |
| pinAstb | output | 1 | Address strobe pin |
| busOverride | output | 1 | Pins forced by halt |
| cpuClkEn | output | 1 | CPU clock enable |
| oscStop | output | 1 | Oscillator stop request |

## Verification
Assertions check four rules on every cycle: a halt request is refused while a release is pending, release occurs one edge after an unmasked request, stop takes priority over halt, and the control word does not move under generic writes or under protected writes made while in standby. They also check that the middle address byte stays frozen for the whole of a halt. The bench scenarios cover what the assertions cannot. These are the reset value, the read view and its zero upper bits, masked requests that must not wake the unit, the exact value latched on the entry edge, and the pin pass-through around each entry into and exit from a standby state.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef struct packed {
    logic setHalt;
    logic setStop;
    logic clrHalt;
    logic clrStop;
  } stbyStrobes_t;

  localparam int HALT_BIT = 0;
  localparam int STOP_BIT = 1;
endpackage

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protWrEn,
  input  logic [REG_W-1:0]   protWdata,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqMask,
  input  logic               haltQ,
  input  logic               stopQ,
  output stbyStrobes_t       strobes,
  output logic               wakePending
);
  logic running;
  logic wrAccepted;

  assign wakePending = |(irqReq & ~irqMask);
  assign running     = !haltQ && !stopQ;
  assign wrAccepted  = protWrEn && running;

  always_comb begin
    strobes.setStop = wrAccepted && protWdata[STOP_BIT];
    strobes.setHalt = wrAccepted && !protWdata[STOP_BIT] && protWdata[HALT_BIT] && !wakePending;
    strobes.clrHalt = haltQ && wakePending;
    strobes.clrStop = stopQ && wakePending;
  end

  // R5: halt refused while a release is pending
  p_refuse_halt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (protWrEn && running && protWdata[HALT_BIT] && !protWdata[STOP_BIT] && wakePending) |=> !haltQ);

  // R6: release on the edge after an unmasked request
  p_release_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && wakePending) |=> !haltQ);

  // R7: stop wins over halt
  p_stop_priority_r7: assert property (@(posedge clk) disable iff (!rstN)
    (protWrEn && running && protWdata[STOP_BIT]) |=> (stopQ && !haltQ));

  // R10: protected writes ignored while in standby
  p_standby_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((haltQ || stopQ) && protWrEn && !wakePending) |=> $stable({stopQ, haltQ}));
endmodule

// File: rtl/stby_dp.sv
module stby_dp
  import stby_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int AD_W  = 8,
  parameter int MID_W = 8,
  parameter int HI_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  stbyStrobes_t     strobes,
  input  logic             busRdEn,
  output logic [REG_W-1:0] rdData,
  output logic             haltQ,
  output logic             stopQ,
  input  logic [AD_W-1:0]  cpuAd,
  input  logic             cpuAdOe,
  input  logic [MID_W-1:0] cpuAddrMid,
  input  logic [HI_W-1:0]  cpuAddrHi,
  input  logic             cpuRdN,
  input  logic             cpuWrN,
  input  logic             cpuAstb,
  output logic [AD_W-1:0]  pinAd,
  output logic             pinAdOe,
  output logic [MID_W-1:0] pinAddrMid,
  output logic [HI_W-1:0]  pinAddrHi,
  output logic             pinRdN,
  output logic             pinWrN,
  output logic             pinAstb
);
  localparam int UNUSED_W = REG_W - 2;

  logic [MID_W-1:0] midHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltQ <= 1'b0;
      stopQ <= 1'b0;
    end else begin
      if (strobes.setHalt)      haltQ <= 1'b1;
      else if (strobes.clrHalt) haltQ <= 1'b0;
      if (strobes.setStop)      stopQ <= 1'b1;
      else if (strobes.clrStop) stopQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       midHold <= '0;
    else if (!haltQ) midHold <= cpuAddrMid;
  end

  assign rdData = busRdEn ? {{UNUSED_W{1'b0}}, stopQ, haltQ} : '0;

  always_comb begin
    if (haltQ) begin
      pinAd      = '0;
      pinAdOe    = 1'b0;
      pinAddrMid = midHold;
      pinAddrHi  = '0;
      pinRdN     = 1'b1;
      pinWrN     = 1'b1;
      pinAstb    = 1'b0;
    end else begin
      pinAd      = cpuAd;
      pinAdOe    = cpuAdOe;
      pinAddrMid = cpuAddrMid;
      pinAddrHi  = cpuAddrHi;
      pinRdN     = cpuRdN;
      pinWrN     = cpuWrN;
      pinAstb    = cpuAstb;
    end
  end

  // R8: middle address byte frozen during halt
  p_mid_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && $past(haltQ)) |-> $stable(pinAddrMid));
endmodule

// File: rtl/stby_ctrl_top.sv
module stby_ctrl_top
  import stby_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int REG_W   = 8,
  parameter int AD_W    = 8,
  parameter int MID_W   = 8,
  parameter int HI_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busRdEn,
  input  logic               busWrEn,
  input  logic [REG_W-1:0]   busWdata,
  input  logic               protWrEn,
  input  logic [REG_W-1:0]   protWdata,
  output logic [REG_W-1:0]   rdData,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqMask,
  input  logic [AD_W-1:0]    cpuAd,
  input  logic               cpuAdOe,
  input  logic [MID_W-1:0]   cpuAddrMid,
  input  logic [HI_W-1:0]    cpuAddrHi,
  input  logic               cpuRdN,
  input  logic               cpuWrN,
  input  logic               cpuAstb,
  output logic [AD_W-1:0]    pinAd,
  output logic               pinAdOe,
  output logic [MID_W-1:0]   pinAddrMid,
  output logic [HI_W-1:0]    pinAddrHi,
  output logic               pinRdN,
  output logic               pinWrN,
  output logic               pinAstb,
  output logic               busOverride,
  output logic               cpuClkEn,
  output logic               oscStop
);
  stbyStrobes_t strobes;
  logic haltQ, stopQ, wakePending;

  stby_ctrl #(.NUM_IRQ(NUM_IRQ), .REG_W(REG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .protWrEn(protWrEn), .protWdata(protWdata),
    .irqReq(irqReq), .irqMask(irqMask), .haltQ(haltQ), .stopQ(stopQ),
    .strobes(strobes), .wakePending(wakePending)
  );

  stby_dp #(.REG_W(REG_W), .AD_W(AD_W), .MID_W(MID_W), .HI_W(HI_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busRdEn(busRdEn), .rdData(rdData),
    .haltQ(haltQ), .stopQ(stopQ),
    .cpuAd(cpuAd), .cpuAdOe(cpuAdOe), .cpuAddrMid(cpuAddrMid), .cpuAddrHi(cpuAddrHi),
    .cpuRdN(cpuRdN), .cpuWrN(cpuWrN), .cpuAstb(cpuAstb),
    .pinAd(pinAd), .pinAdOe(pinAdOe), .pinAddrMid(pinAddrMid), .pinAddrHi(pinAddrHi),
    .pinRdN(pinRdN), .pinWrN(pinWrN), .pinAstb(pinAstb)
  );

  assign busOverride = haltQ;
  assign cpuClkEn    = !(haltQ || stopQ);
  assign oscStop     = stopQ;

  // R3: generic writes never move the control word
  p_bus_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !protWrEn && !wakePending && (busWdata != '0)) |=> $stable({stopQ, haltQ}));
endmodule

// File: tb/stby_ctrl_top_tb_top.sv
module stby_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic busRdEn = 0, busWrEn = 0, protWrEn = 0;
  logic [7:0] busWdata = 0, protWdata = 0, rdData;
  logic [NIRQ-1:0] irqReq = 0, irqMask = 0;
  logic [7:0] cpuAd = 0, cpuAddrMid = 0, pinAd, pinAddrMid;
  logic [3:0] cpuAddrHi = 0, pinAddrHi;
  logic cpuAdOe = 0, cpuRdN = 1, cpuWrN = 1, cpuAstb = 0;
  logic pinAdOe, pinRdN, pinWrN, pinAstb, busOverride, cpuClkEn, oscStop;

  int nChecks = 0, nFails = 0;
  logic mHlt = 0, mStp = 0;
  logic [7:0] mMid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_ctrl_top dut_i (
    .clk(clk), .rstN(rstN), .busRdEn(busRdEn), .busWrEn(busWrEn), .busWdata(busWdata),
    .protWrEn(protWrEn), .protWdata(protWdata), .rdData(rdData),
    .irqReq(irqReq), .irqMask(irqMask), .cpuAd(cpuAd), .cpuAdOe(cpuAdOe),
    .cpuAddrMid(cpuAddrMid), .cpuAddrHi(cpuAddrHi), .cpuRdN(cpuRdN), .cpuWrN(cpuWrN),
    .cpuAstb(cpuAstb), .pinAd(pinAd), .pinAdOe(pinAdOe), .pinAddrMid(pinAddrMid),
    .pinAddrHi(pinAddrHi), .pinRdN(pinRdN), .pinWrN(pinWrN), .pinAstb(pinAstb),
    .busOverride(busOverride), .cpuClkEn(cpuClkEn), .oscStop(oscStop)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRd();
    return busRdEn ? {6'b0, mStp, mHlt} : 8'h00;
  endfunction

  function automatic logic [23:0] expPins();
    if (mHlt) return {8'h00, 1'b0, mMid, 4'h0, 1'b1, 1'b1, 1'b0};
    return {cpuAd, cpuAdOe, cpuAddrMid, cpuAddrHi, cpuRdN, cpuWrN, cpuAstb};
  endfunction

  task automatic checkAll(string ctx);
    check({ctx, " R2 rdData"}, rdData, expRd());
    check({ctx, " R4/R7 cpuClkEn"}, cpuClkEn, !(mHlt || mStp));
    check({ctx, " R7 oscStop"}, oscStop, mStp);
    check({ctx, " R4 busOverride"}, busOverride, mHlt);
    check({ctx, mHlt ? " R8 pins" : " R9 pins"},
          {pinAd, pinAdOe, pinAddrMid, pinAddrHi, pinRdN, pinWrN, pinAstb}, expPins());
  endtask

  // drive inputs already set; advance one clock, update model, check at negedge
  task automatic step(string ctx);
    logic pend, run, oldHlt;
    @(posedge clk);
    pend = |(irqReq & ~irqMask);
    run = !mHlt && !mStp;
    oldHlt = mHlt;
    if (run && protWrEn) begin
      if (protWdata[1]) mStp = 1;
      else if (protWdata[0] && !pend) mHlt = 1;
    end else begin
      if (mHlt && pend) mHlt = 0;
      if (mStp && pend) mStp = 0;
    end
    if (!oldHlt) mMid = cpuAddrMid;
    @(negedge clk);
    checkAll(ctx);
  endtask

  task automatic idle();
    protWrEn = 0; busWrEn = 0; irqReq = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1;
    busRdEn = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 8'h00);
    check("R1 cpuClkEn", cpuClkEn, 1);
    check("R1 oscStop", oscStop, 0);
    check("R1 busOverride", busOverride, 0);

    // R3 generic write of all ones
    busWrEn = 1; busWdata = 8'hFF; step("R3 genwr");
    check("R3 word unchanged", rdData, 8'h00);
    busWrEn = 1; busWdata = 8'h01; step("R3 genwr2");
    check("R3 word unchanged 2", rdData, 8'h00);
    idle();

    // R4 halt entry, R8 latched mid address
    cpuAddrMid = 8'hA5; cpuAd = 8'h3C; cpuAdOe = 1; cpuAddrHi = 4'hF; cpuRdN = 0; cpuAstb = 1;
    protWrEn = 1; protWdata = 8'h01; step("R4 enter");
    protWrEn = 0;
    check("R4 halt bit", rdData, 8'h01);
    check("R4 cpuClkEn low", cpuClkEn, 0);
    cpuAddrMid = 8'h5A; #1;
    check("R8 mid held", pinAddrMid, 8'hA5);
    check("R8 ad float", pinAdOe, 0);
    check("R8 rd strobe high", pinRdN, 1);
    // R10 protected write during halt ignored
    protWrEn = 1; protWdata = 8'h02; step("R10 wr in halt");
    protWrEn = 0;
    check("R10 word after ignored wr", rdData, 8'h01);
    // R6 masked request does not release
    irqReq = 8'h10; irqMask = 8'h10; step("R6 masked");
    check("R6 still halted", rdData, 8'h01);
    irqMask = 8'h00; step("R6 release");
    check("R6 released", rdData, 8'h00);
    check("R9 passthrough mid", pinAddrMid, 8'h5A);
    idle(); step("idle");

    // R5 refused halt
    irqReq = 8'h02; irqMask = 8'h00; protWrEn = 1; protWdata = 8'h01; step("R5 refuse");
    check("R5 halt refused", rdData, 8'h00);
    check("R5 clk still on", cpuClkEn, 1);
    idle(); step("idle");

    // R7 stop priority and release
    protWrEn = 1; protWdata = 8'h03; step("R7 stop");
    protWrEn = 0;
    check("R7 stop only", rdData, 8'h02);
    check("R7 oscStop", oscStop, 1);
    irqReq = 8'h80; step("R7 wake");
    check("R7 stop cleared", rdData, 8'h00);
    idle();
    busRdEn = 0; step("R2 no read");
    check("R2 rdData idle", rdData, 8'h00);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      busRdEn   = $urandom_range(0, 3) != 0;
      busWrEn   = $urandom_range(0, 3) == 0;
      busWdata  = 8'($urandom);
      protWrEn  = $urandom_range(0, 5) == 0;
      protWdata = 8'($urandom_range(0, 3));
      irqReq    = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'h00;
      irqMask   = 8'($urandom);
      cpuAd     = 8'($urandom);
      cpuAdOe   = 1'($urandom);
      cpuAddrMid = 8'($urandom);
      cpuAddrHi = 4'($urandom);
      cpuRdN    = 1'($urandom);
      cpuWrN    = 1'($urandom);
      cpuAstb   = 1'($urandom);
      step("random R3 R4 R5 R6 R7 R10");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule